// File: doc/BRIEF.md
# Two-rate dual-slope ADC sequencer

This block is the digital half of an integrating converter whose run-down is split into two speeds. Each conversion follows a fixed order. First the integrator is zeroed. Then the input is integrated for a fixed time. Last, the charge is removed in two parts. A coarse part applies the large reference until the comparator flips. A fine part then applies a reference sixty-four times weaker, with the opposite sign, until the comparator flips back. The controller drives four analog switch enables and a reference-sign select. It watches one comparator bit and counts clocks. From the two counts it builds a 15-bit magnitude, a polarity flag, an over-range flag and an end-of-conversion strobe.

Every conversion takes the same number of clocks. Auto-zero absorbs whatever part of the run-down time a given input does not use, so conversions come at a steady rate. With the default parameters, a coarse count C (up to 512) and a fine count F (up to 64) give a magnitude of 64·C − F. This gives 15 bits of resolution with at most 576 run-down clocks.

Top module: `adc2r_seq`

## Requirements
- R1: The active enable steps through zero (sw_zero_o), then integrate (sw_int_o), then coarse (sw_crs_o), then fine (sw_fin_o), then back to zero. After a coarse time-out the step is coarse to zero. At most one enable is high in any clock, and between any two different phases there is exactly one clock with all four enables low.
- R2: The integrate enable rises every 1280 clocks, whatever the comparator does. Reset leaves the block in auto-zero. Counting falling clock edges after the one at which reset is released, the integrate enable is first seen high at the 445th.
- R3: Integrate lasts exactly 256 clocks. The polarity is the value of cmp_i sampled at the end of the last integrate clock, and only that clock counts. It is reported on pos_o, where 1 means cmp_i was high.
- R4: ref_pos_o is the inverse of the polarity during coarse clocks, equals the polarity during fine clocks, and is 0 in every other clock.
- R5: The coarse phase ends with the first clock at whose end cmp_i differs from the polarity. That clock is counted in C, and the phase lasts at most 512 clocks.
- R6: The fine phase starts one idle clock after a coarse crossing. It ends with the first clock at whose end cmp_i equals the polarity. That clock is counted in F, and the phase lasts at most 64 clocks.
- R7: When both phases end on a crossing, code_o = 64·C − F and over_o = 0.
- R8: If the coarse phase runs 512 clocks without a crossing, the fine phase is skipped, code_o = 32767 and over_o = 1.
- R9: If the fine phase runs 64 clocks without a crossing, code_o = 32767 and over_o = 1.
- R10: eoc_o is high for exactly one clock: the clock right after the last run-down clock. code_o, pos_o and over_o take their new values in that clock and hold them until the next eoc_o.
- R11: While reset is held, sw_zero_o is 1 and sw_int_o, sw_crs_o, sw_fin_o, ref_pos_o, code_o, pos_o, over_o and eoc_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_i | input | 1 | Comparator output, high when the integrator is above zero |
| sw_zero_o | output | 1 | Auto-zero switch enable |
| sw_int_o | output | 1 | Signal-integrate switch enable |
| sw_crs_o | output | 1 | Coarse-reference run-down switch enable |
| sw_fin_o | output | 1 | Fine-reference run-down switch enable |
| ref_pos_o | output | 1 | Reference sign select during run-down, 1 = positive |
| code_o | output | 15 | Conversion magnitude |
| pos_o | output | 1 | Polarity of the last conversion |
| over_o | output | 1 | Last conversion saturated |
| eoc_o | output | 1 | One-clock end-of-conversion strobe |

## Verification
The bench models the integrator as a residue. It sweeps magnitudes across the coarse-step edges: 63, 64 and 65, where an off-by-one in either counter moves the code by one or by 64. It also covers the top of the range, where a crossing on the 512th coarse clock must not be mistaken for a time-out. Before the last integrate clock it drives the comparator to the wrong polarity, so a design that latches the sign early reports the wrong polarity and runs the wrong way. It forces a frozen comparator in the fine phase and inputs beyond full scale, so a design that does not saturate, or that runs a fine phase after a coarse time-out, is caught by its code or by the phase order. The integrate period is measured in every frame, so any run-down clock not taken back out of auto-zero shows up as a period other than 1280.

// File: rtl/adc2r_pkg.sv
package adc2r_pkg;

    localparam int unsigned DEF_COARSE_BITS = 9;
    localparam int unsigned DEF_FINE_BITS   = 6;
    localparam int unsigned DEF_INT_CLKS    = 256;
    localparam int unsigned DEF_FRAME_CLKS  = 1280;

    // Controller phases; G0..G3 are the single idle clocks between phases.
    typedef enum logic [2:0] {
        PH_AZ  = 3'd0,
        PH_G0  = 3'd1,
        PH_INT = 3'd2,
        PH_G1  = 3'd3,
        PH_CRS = 3'd4,
        PH_G2  = 3'd5,
        PH_FIN = 3'd6,
        PH_G3  = 3'd7
    } phase_e;

    typedef struct packed {
        logic zero;
        logic integ;
        logic crs;
        logic fin;
    } sw_t;

    typedef struct packed {
        logic pos;
        logic over;
    } flags_t;

    // Fixed part of a frame: integrate, both run-down limits and four idle clocks.
    function automatic int unsigned az_start(input int unsigned int_clks,
                                             input int unsigned coarse_bits,
                                             input int unsigned fine_bits);
        return int_clks + (2 ** coarse_bits) + (2 ** fine_bits) + 4;
    endfunction

    function automatic sw_t phase_switches(input phase_e p);
        sw_t s;
        s = '0;
        case (p)
            PH_AZ:   s.zero  = 1'b1;
            PH_INT:  s.integ = 1'b1;
            PH_CRS:  s.crs   = 1'b1;
            PH_FIN:  s.fin   = 1'b1;
            default: s = '0;
        endcase
        return s;
    endfunction

    function automatic logic ref_polarity(input phase_e p, input logic pol);
        case (p)
            PH_CRS:  return ~pol;
            PH_FIN:  return pol;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/adc2r_frame_timer.sv
module adc2r_frame_timer #(
    parameter int unsigned FRAME_CLKS = 1280,
    parameter int unsigned START      = 836,
    localparam int unsigned FC_W      = $clog2(FRAME_CLKS)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [FC_W-1:0] fc_o,
    output logic            wrap_o
);

    localparam logic [FC_W-1:0] LAST  = FC_W'(FRAME_CLKS - 1);
    localparam logic [FC_W-1:0] FIRST = FC_W'(START);

    logic [FC_W-1:0] fc;

    always_ff @(posedge clk) begin
        if (rst) begin
            fc <= FIRST;
        end else if (fc == LAST) begin
            fc <= '0;
        end else begin
            fc <= fc + 1'b1;
        end
    end

    assign fc_o   = fc;
    assign wrap_o = (fc == LAST);

    // R2: the frame position never leaves the frame
    assert_fc_range_R2: assert property (@(posedge clk) disable iff (rst)
        fc <= LAST);

endmodule

// File: rtl/adc2r_phase_ctrl.sv
module adc2r_phase_ctrl
    import adc2r_pkg::*;
#(
    parameter int unsigned COARSE_BITS = 9,
    parameter int unsigned FINE_BITS   = 6,
    parameter int unsigned INT_CLKS    = 256,
    parameter int unsigned FC_W        = 11,
    localparam int unsigned CNT_W      = ((COARSE_BITS > FINE_BITS) ? COARSE_BITS : FINE_BITS) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FC_W-1:0]  fc_i,
    input  logic             wrap_i,
    input  logic             cmp_i,
    output phase_e           phase_o,
    output logic             pol_o,
    output logic             ev_valid_o,
    output logic             ev_sat_o,
    output logic [CNT_W-1:0] ev_coarse_o,
    output logic [CNT_W-1:0] ev_fine_o
);

    localparam logic [CNT_W-1:0] COARSE_MAX = CNT_W'(2 ** COARSE_BITS);
    localparam logic [CNT_W-1:0] FINE_MAX   = CNT_W'(2 ** FINE_BITS);
    localparam logic [FC_W-1:0]  INT_END    = FC_W'(INT_CLKS);

    phase_e           st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W-1:0] c_hold, c_hold_n;
    logic             pol, pol_n;
    logic             fine_go, fine_go_n;
    logic [CNT_W-1:0] steps;
    logic             cross_c, cross_f;

    assign steps   = cnt + 1'b1;
    assign cross_c = (cmp_i != pol);
    assign cross_f = (cmp_i == pol);

    always_comb begin
        st_n        = st;
        cnt_n       = cnt;
        c_hold_n    = c_hold;
        pol_n       = pol;
        fine_go_n   = fine_go;
        ev_valid_o  = 1'b0;
        ev_sat_o    = 1'b0;
        ev_fine_o   = steps;
        case (st)
            PH_AZ: begin
                if (wrap_i) st_n = PH_G0;
            end
            PH_G0: st_n = PH_INT;
            PH_INT: begin
                if (fc_i == INT_END) begin
                    st_n  = PH_G1;
                    pol_n = cmp_i;
                end
            end
            PH_G1: begin
                st_n  = PH_CRS;
                cnt_n = '0;
            end
            PH_CRS: begin
                if (cross_c) begin
                    st_n      = PH_G2;
                    c_hold_n  = steps;
                    fine_go_n = 1'b1;
                    cnt_n     = '0;
                end else if (steps == COARSE_MAX) begin
                    st_n       = PH_G2;
                    c_hold_n   = steps;
                    fine_go_n  = 1'b0;
                    cnt_n      = '0;
                    ev_valid_o = 1'b1;
                    ev_sat_o   = 1'b1;
                end else begin
                    cnt_n = steps;
                end
            end
            PH_G2: st_n = fine_go ? PH_FIN : PH_AZ;
            PH_FIN: begin
                if (cross_f || (steps == FINE_MAX)) begin
                    st_n       = PH_G3;
                    cnt_n      = '0;
                    ev_valid_o = 1'b1;
                    ev_sat_o   = ~cross_f;
                end else begin
                    cnt_n = steps;
                end
            end
            PH_G3: st_n = PH_AZ;
            default: st_n = PH_AZ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= PH_AZ;
            cnt     <= '0;
            c_hold  <= '0;
            pol     <= 1'b0;
            fine_go <= 1'b0;
        end else begin
            st      <= st_n;
            cnt     <= cnt_n;
            c_hold  <= c_hold_n;
            pol     <= pol_n;
            fine_go <= fine_go_n;
        end
    end

    assign phase_o     = st;
    assign pol_o       = pol;
    assign ev_coarse_o = c_hold;

    // R5: coarse counter stays below its limit while coarse run-down is active
    assert_coarse_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (st == PH_CRS) |-> (cnt < COARSE_MAX));

    // R6: fine counter stays below its limit while fine run-down is active
    assert_fine_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (st == PH_FIN) |-> (cnt < FINE_MAX));

    // R6: fine run-down is entered only two clocks after a coarse clock
    assert_fine_after_coarse_R6: assert property (@(posedge clk) disable iff (rst)
        (st == PH_FIN && $past(st) != PH_FIN) |-> ($past(st, 2) == PH_CRS));

    // R3: integrate starts on frame position 1
    assert_int_align_R3: assert property (@(posedge clk) disable iff (rst)
        (st == PH_INT && $past(st) != PH_INT) |-> (fc_i == FC_W'(1)));

    // R3: integrate ends after its fixed length
    assert_int_len_R3: assert property (@(posedge clk) disable iff (rst)
        (st == PH_G1) |-> ($past(fc_i) == INT_END));

endmodule

// File: rtl/adc2r_result.sv
module adc2r_result
    import adc2r_pkg::*;
#(
    parameter int unsigned COARSE_BITS = 9,
    parameter int unsigned FINE_BITS   = 6,
    parameter int unsigned CNT_W       = 10,
    localparam int unsigned RES_W      = COARSE_BITS + FINE_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid_i,
    input  logic             ev_sat_i,
    input  logic [CNT_W-1:0] ev_coarse_i,
    input  logic [CNT_W-1:0] ev_fine_i,
    input  logic             pol_i,
    output logic [RES_W-1:0] code_o,
    output logic             pos_o,
    output logic             over_o,
    output logic             eoc_o
);

    localparam int unsigned WIDE_W = RES_W + 1;
    localparam logic [RES_W-1:0] CODE_MAX = '1;

    logic [WIDE_W-1:0] scaled;
    logic [WIDE_W-1:0] diff;
    logic              sat;
    logic [RES_W-1:0]  code, code_n;
    flags_t            flg, flg_n;
    logic              eoc;

    assign scaled = WIDE_W'(ev_coarse_i) << FINE_BITS;
    assign diff   = scaled - WIDE_W'(ev_fine_i);
    assign sat    = ev_sat_i | diff[WIDE_W-1];

    always_comb begin
        code_n = code;
        flg_n  = flg;
        if (ev_valid_i) begin
            code_n   = sat ? CODE_MAX : diff[RES_W-1:0];
            flg_n.over = sat;
            flg_n.pos  = pol_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
            flg  <= '0;
            eoc  <= 1'b0;
        end else begin
            code <= code_n;
            flg  <= flg_n;
            eoc  <= ev_valid_i;
        end
    end

    assign code_o = code;
    assign pos_o  = flg.pos;
    assign over_o = flg.over;
    assign eoc_o  = eoc;

    // R10: the strobe lasts a single clock
    assert_eoc_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        eoc |=> !eoc);

    // R10: results hold between strobes
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !eoc |-> ($stable(code) && $stable(flg)));

    // R8: a saturated result always carries the full-scale code
    assert_sat_code_R8: assert property (@(posedge clk) disable iff (rst)
        (eoc && flg.over) |-> (code == CODE_MAX));

endmodule

// File: rtl/adc2r_seq.sv
module adc2r_seq
    import adc2r_pkg::*;
#(
    parameter int unsigned COARSE_BITS = DEF_COARSE_BITS,
    parameter int unsigned FINE_BITS   = DEF_FINE_BITS,
    parameter int unsigned INT_CLKS    = DEF_INT_CLKS,
    parameter int unsigned FRAME_CLKS  = DEF_FRAME_CLKS,
    localparam int unsigned RES_W      = COARSE_BITS + FINE_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_i,
    output logic             sw_zero_o,
    output logic             sw_int_o,
    output logic             sw_crs_o,
    output logic             sw_fin_o,
    output logic             ref_pos_o,
    output logic [RES_W-1:0] code_o,
    output logic             pos_o,
    output logic             over_o,
    output logic             eoc_o
);

    localparam int unsigned FC_W     = $clog2(FRAME_CLKS);
    localparam int unsigned CNT_W    = ((COARSE_BITS > FINE_BITS) ? COARSE_BITS : FINE_BITS) + 1;
    localparam int unsigned AZ_START = az_start(INT_CLKS, COARSE_BITS, FINE_BITS);

    logic [FC_W-1:0]  fc;
    logic             wrap;
    phase_e           phase;
    logic             pol;
    logic             ev_valid, ev_sat;
    logic [CNT_W-1:0] ev_coarse, ev_fine;
    sw_t              sw;

    adc2r_frame_timer #(
        .FRAME_CLKS (FRAME_CLKS),
        .START      (AZ_START)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .fc_o   (fc),
        .wrap_o (wrap)
    );

    adc2r_phase_ctrl #(
        .COARSE_BITS (COARSE_BITS),
        .FINE_BITS   (FINE_BITS),
        .INT_CLKS    (INT_CLKS),
        .FC_W        (FC_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .fc_i        (fc),
        .wrap_i      (wrap),
        .cmp_i       (cmp_i),
        .phase_o     (phase),
        .pol_o       (pol),
        .ev_valid_o  (ev_valid),
        .ev_sat_o    (ev_sat),
        .ev_coarse_o (ev_coarse),
        .ev_fine_o   (ev_fine)
    );

    adc2r_result #(
        .COARSE_BITS (COARSE_BITS),
        .FINE_BITS   (FINE_BITS),
        .CNT_W       (CNT_W)
    ) u_result (
        .clk         (clk),
        .rst         (rst),
        .ev_valid_i  (ev_valid),
        .ev_sat_i    (ev_sat),
        .ev_coarse_i (ev_coarse),
        .ev_fine_i   (ev_fine),
        .pol_i       (pol),
        .code_o      (code_o),
        .pos_o       (pos_o),
        .over_o      (over_o),
        .eoc_o       (eoc_o)
    );

    assign sw        = phase_switches(phase);
    assign sw_zero_o = sw.zero;
    assign sw_int_o  = sw.integ;
    assign sw_crs_o  = sw.crs;
    assign sw_fin_o  = sw.fin;
    assign ref_pos_o = ref_polarity(phase, pol);

    // R1: two different active enables are always separated by an idle clock
    assert_idle_between_R1: assert property (@(posedge clk) disable iff (rst)
        (sw != '0 && $past(sw) != '0) |-> (sw == $past(sw)));

    // R10: the strobe follows directly on a run-down clock
    assert_eoc_source_R10: assert property (@(posedge clk) disable iff (rst)
        eoc_o |-> $past(sw.crs || sw.fin));

endmodule

// File: tb/test_adc2r_seq.sv
module test_adc2r_seq;

    localparam int FRAME  = 1280;
    localparam int INTC   = 256;
    localparam int CMAX   = 512;
    localparam int FMAX   = 64;
    localparam int FULL   = 32767;
    localparam int NVEC   = 100;
    localparam int WDOG   = 195000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp = 1'b0;
    logic        sw_zero, sw_int, sw_crs, sw_fin, ref_pos;
    logic [14:0] code;
    logic        pos, over, eoc;

    int nchk = 0;
    int nerr = 0;

    // model and monitor state
    bit s_cur = 1'b0;
    int m_cur = 0;
    bit stuck = 1'b0;
    int res   = 0;
    int n_int = 0, n_dc = 0, n_df = 0;
    int cyc = 0, t_int = -1, period = 0;
    int cur_ph = 1, zrun = 0, ph_now = 1, ph_prev = 1;
    int gap_bad = 0, order_bad = 0, overlap_bad = 0, ref_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adc2r_seq i_adc2r_seq (
        .clk       (clk),
        .rst       (rst),
        .cmp_i     (cmp),
        .sw_zero_o (sw_zero),
        .sw_int_o  (sw_int),
        .sw_crs_o  (sw_crs),
        .sw_fin_o  (sw_fin),
        .ref_pos_o (ref_pos),
        .code_o    (code),
        .pos_o     (pos),
        .over_o    (over),
        .eoc_o     (eoc)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit step_ok(input int from, input int to);
        return (from == 1 && to == 2) || (from == 2 && to == 3) ||
               (from == 3 && to == 4) || (from == 3 && to == 1) ||
               (from == 4 && to == 1);
    endfunction

    // Integrator model and phase monitor, evaluated between clock edges.
    always @(negedge clk) begin
        int ph;
        cyc++;
        if (!rst) begin
            ph = 0;
            if ($countones({sw_zero, sw_int, sw_crs, sw_fin}) > 1) overlap_bad++;
            if (sw_zero) ph = 1;
            if (sw_int)  ph = 2;
            if (sw_crs)  ph = 3;
            if (sw_fin)  ph = 4;
            ph_prev = ph_now;
            ph_now  = ph;
            if (ph == 0) begin
                zrun++;
            end else if (ph != cur_ph) begin
                if (zrun != 1) gap_bad++;
                if (!step_ok(cur_ph, ph)) order_bad++;
                if (ph == 2) begin
                    n_int = 0; n_dc = 0; n_df = 0;
                    if (t_int >= 0) period = cyc - t_int;
                    t_int = cyc;
                end
                cur_ph = ph;
                zrun   = 0;
            end else begin
                zrun = 0;
            end
            if (sw_int) begin
                n_int++;
                cmp = (n_int == INTC) ? s_cur : !s_cur;
            end
            if (sw_crs) begin
                n_dc++;
                res = m_cur - 64 * n_dc;
                cmp = s_cur ^ (res < 0);
                if (ref_pos != !s_cur) ref_bad++;
            end else if (sw_fin) begin
                n_df++;
                if (!stuck) begin
                    res = res + 1;
                    cmp = s_cur ^ (res < 0);
                end
                if (ref_pos != s_cur) ref_bad++;
            end else if (ref_pos != 1'b0) begin
                ref_bad++;
            end
        end
    end

    initial begin
        wait (cyc > WDOG);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, WDOG);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    task automatic get_vec(input int i, output bit s, output int m, output bit st);
        st = 1'b0;
        case (i)
            0:  begin s = 1; m = 0;     end
            1:  begin s = 0; m = 0;     end
            2:  begin s = 1; m = 1;     end
            3:  begin s = 0; m = 63;    end
            4:  begin s = 1; m = 64;    end
            5:  begin s = 0; m = 65;    end
            6:  begin s = 1; m = 4095;  end
            7:  begin s = 0; m = 32703; end
            8:  begin s = 1; m = 32704; end
            9:  begin s = 0; m = 32767; end
            10: begin s = 1; m = 32768; end
            11: begin s = 0; m = 50000; end
            12: begin s = 1; m = 1000;  st = 1'b1; end
            13: begin s = 0; m = 64;    st = 1'b1; end
            14: begin s = 1; m = 12345; end
            15: begin s = 0; m = 20000; end
            default: begin
                m = (i * 7919 + i * i * 13) % 34000;
                s = i[0] ^ i[1];
            end
        endcase
    endtask

    task automatic load_vec(input int i);
        bit s, st;
        int m;
        get_vec(i, s, m, st);
        s_cur = s;
        m_cur = m;
        stuck = st;
    endtask

    task automatic wait_eoc(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (eoc) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        bit ok;
        int k;
        int c_exp, f_exp, code_exp, ov_exp;
        int code_seen;

        load_vec(0);
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11", "sw_zero in reset", int'(sw_zero), 1);
        chk("R11", "sw_int in reset",  int'(sw_int),  0);
        chk("R11", "sw_crs in reset",  int'(sw_crs),  0);
        chk("R11", "sw_fin in reset",  int'(sw_fin),  0);
        chk("R11", "ref_pos in reset", int'(ref_pos), 0);
        chk("R11", "code in reset",    int'(code),    0);
        chk("R11", "flags in reset",   int'({pos, over, eoc}), 0);
        rst = 1'b0;

        // R2: first integrate after reset release
        k = 0;
        while (!sw_int && k < 2000) begin
            @(negedge clk);
            k++;
        end
        chk("R2", "edges to first integrate", k, 445);

        for (int i = 0; i < NVEC; i++) begin
            wait_eoc(ok);
            chk("R10", "strobe seen", int'(ok), 1);
            if (!ok) break;
            #1;
            ov_exp   = (stuck || m_cur >= 32768) ? 1 : 0;
            c_exp    = (m_cur >= 32768) ? CMAX : (m_cur / 64 + 1);
            f_exp    = (m_cur >= 32768) ? 0 : (stuck ? FMAX : (64 * c_exp - m_cur));
            code_exp = ov_exp ? FULL : m_cur;
            if (stuck)
                chk("R9", "code on fine time-out", int'(code), code_exp);
            else if (m_cur >= 32768)
                chk("R8", "code on coarse time-out", int'(code), code_exp);
            else
                chk("R7", "code", int'(code), code_exp);
            chk(m_cur >= 32768 ? "R8" : (stuck ? "R9" : "R7"), "over flag", int'(over), ov_exp);
            chk("R3", "polarity", int'(pos), int'(s_cur));
            chk("R3", "integrate length", n_int, INTC);
            chk("R5", "coarse clocks", n_dc, c_exp);
            chk("R6", "fine clocks", n_df, f_exp);
            chk("R10", "strobe follows run-down", int'(ph_prev == 3 || ph_prev == 4), 1);
            chk("R10", "strobe in idle clock", ph_now, 0);
            if (i > 0) chk("R2", "integrate period", period, FRAME);
            chk("R1", "idle gaps", gap_bad, 0);
            chk("R1", "phase order", order_bad, 0);
            chk("R1", "enable overlap", overlap_bad, 0);
            chk("R4", "reference sign", ref_bad, 0);
            code_seen = int'(code);
            load_vec(i + 1);
            @(negedge clk);
            chk("R10", "strobe single clock", int'(eoc), 0);
            chk("R10", "code held", int'(code), code_seen);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule